// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt requests from a set of internal level sources and a small group of external pins, and drives one ordinary interrupt line towards a processor. Every ordinary source carries a 3-bit priority; the block always knows which pending, enabled source has the highest level and exposes its number and level through a read register. Software uses the same register port to program priorities, choose how each external pin is conditioned, inspect the raw pending vector and clear latched edge requests.

Each external pin is synchronised through two flops and then treated either as a level input, active high or low, or as an edge input that latches on a rising or a falling transition. A separate active-low fast-interrupt pin follows its own path. It is always detected on its falling edge, is latched, and drives its own output until software clears it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority is 0, the pin configuration register reads 0, and irq_o, fiq_o and the winner register (address 0x24) are all 0.
- R2: A source whose priority is 0 is disabled and never asserts irq_o, even when it is pending.
- R3: irq_o is high exactly when at least one pending source has a non-zero priority.
- R4: The winner register at address 0x24 reads {valid at bit 8, level at bits 7:5, source number at bits 4:0}. It names the pending enabled source with the highest priority; among equal levels the lowest source number wins.
- R5: Internal sources 0 to 22 are active-high level requests. Bit k of the pending register (address 0x23) follows internal input k with no latching.
- R6: External pin p is source 23+p. Its 2-bit field at bits [2p+1:2p] of the configuration register (address 0x20) holds {edge, pol}. With edge=0 the source is pending while the pin is high (pol=1) or low (pol=0), and it drops when the pin goes inactive.
- R7: With edge=1 a rising (pol=1) or falling (pol=0) transition latches the source as pending; the opposite transition neither sets nor clears it.
- R8: Writing source number n to the clear register (address 0x21) removes a latched edge request of source n only. The write does not affect other sources or level requests.
- R9: A falling edge on fiq_ni latches fiq_o high. A rising edge has no effect. Any write to address 0x22 clears it.
- R10: A pin change reaches the pending state after exactly two clock edges through the synchroniser.
- R11: Writing address k (0 to 26) sets the priority of source k from wdata bits 2:0, and reading it back returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_irq_i | input | 23 | Internal level requests, active high |
| ext_irq_i | input | 4 | External interrupt pins, asynchronous |
| fiq_ni | input | 1 | Fast-interrupt pin, active low, asynchronous |
| addr_i | input | 6 | Register address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is the long chain of arbitration outcomes: each one depends on the whole priority map together with the pending set. The bench programs a scattered priority pattern, raises every internal source, and then removes the current winner after each read. This walks the winner down through every level and through the ties, and each step is compared with a model in the bench. The latched edge paths are driven with the opposite transition and with clears aimed at a neighbouring source, so that a request which should survive is seen to survive.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_INT  = 23;
  localparam int NUM_EXT  = 4;
  localparam int PRIO_W   = 3;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int NUM_SRC  = NUM_INT + NUM_EXT;
  localparam int ID_W     = $clog2(NUM_SRC);

  localparam logic [ADDR_W-1:0] A_CFG     = 6'h20;
  localparam logic [ADDR_W-1:0] A_CLR     = 6'h21;
  localparam logic [ADDR_W-1:0] A_FIQ_CLR = 6'h22;
  localparam logic [ADDR_W-1:0] A_PEND    = 6'h23;
  localparam logic [ADDR_W-1:0] A_WIN     = 6'h24;

  typedef struct packed {
    logic edge_mode;
    logic pol;
  } pin_cfg_t;
endpackage

// File: rtl/pic_pin_cond.sv
module pic_pin_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, prev_q, latch_q;
  logic lvl_act, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_act = pol_i ? s2_q : ~s2_q;
  assign hit     = edge_mode_i & (pol_i ? (s2_q & ~prev_q) : (~s2_q & prev_q));

  // a new edge outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= 1'b0;
    else if (hit)    latch_q <= 1'b1;
    else if (clr_i)  latch_q <= 1'b0;
  end

  assign pend_o = edge_mode_i ? latch_q : lvl_act;

  p_edge_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && latch_q && !clr_i) |=> latch_q);
  p_edge_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !latch_q);
endmodule

// File: rtl/pic_fiq_path.sv
module pic_fiq_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fiq_ni,
  input  logic clr_i,
  output logic fiq_o
);
  logic s1_q, s2_q, prev_q, latch_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= fiq_ni;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = ~s2_q & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= 1'b0;
    else if (fall)  latch_q <= 1'b1;
    else if (clr_i) latch_q <= 1'b0;
  end

  assign fiq_o = latch_q;

  p_fiq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o && !clr_i) |=> fiq_o);
  p_fiq_low_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fiq_o) |-> !$past(fiq_ni, 2));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N      = 27,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        pend_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [ID_W-1:0]     id_o,
  output logic [PRIO_W-1:0]   lvl_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    lvl_o = '0;
    id_o  = '0;
    for (int k = 0; k < N; k++) begin
      if (pend_i[k] && (prio_i[k*PRIO_W +: PRIO_W] > lvl_o)) begin
        lvl_o = prio_i[k*PRIO_W +: PRIO_W];
        id_o  = ID_W'(k);
      end
    end
  end

  assign valid_o = (lvl_o != '0);

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int k = 0; k < N; k++) begin
        p_no_higher_r4: assert (!(pend_i[k] && prio_i[k*PRIO_W +: PRIO_W] > lvl_o))
          else $error("source %0d outranks winner", k);
        p_tie_low_r4: assert (!(valid_o && pend_i[k] && k < int'(id_o) &&
                                prio_i[k*PRIO_W +: PRIO_W] == lvl_o))
          else $error("tie not resolved to lowest index at %0d", k);
      end
    end
  end

  p_win_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[id_o] && prio_i[id_o*PRIO_W +: PRIO_W] == lvl_o));
  p_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> !valid_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_INT = NUM_INT,
  parameter int N_EXT = NUM_EXT,
  parameter int P_W   = PRIO_W,
  parameter int A_W   = ADDR_W,
  parameter int D_W   = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_INT-1:0] int_irq_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic             fiq_ni,
  input  logic [A_W-1:0]   addr_i,
  input  logic [D_W-1:0]   wdata_i,
  input  logic             we_i,
  output logic [D_W-1:0]   rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int N_S   = N_INT + N_EXT;
  localparam int I_W   = $clog2(N_S);
  localparam int CFG_W = 2 * N_EXT;

  logic [P_W-1:0]   prio_q [N_S];
  logic [N_S*P_W-1:0] prio_flat;
  pin_cfg_t [N_EXT-1:0] cfg_q;
  logic [N_EXT-1:0] ext_pend, ext_clr;
  logic [N_S-1:0]   pend;
  logic             win_valid;
  logic [I_W-1:0]   win_id;
  logic [P_W-1:0]   win_lvl;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[D_W-1:CFG_W];

  for (genvar k = 0; k < N_S; k++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        prio_q[k] <= '0;
      else if (we_i && addr_i == A_W'(k)) prio_q[k] <= wdata_i[P_W-1:0];
    end
    assign prio_flat[k*P_W +: P_W] = prio_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cfg_q <= '0;
    else if (we_i && addr_i == A_CFG) cfg_q <= wdata_i[CFG_W-1:0];
  end

  for (genvar p = 0; p < N_EXT; p++) begin : g_pin
    assign ext_clr[p] = we_i && addr_i == A_CLR && wdata_i[I_W-1:0] == I_W'(N_INT + p);
    pic_pin_cond i_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (ext_irq_i[p]),
      .edge_mode_i(cfg_q[p].edge_mode),
      .pol_i      (cfg_q[p].pol),
      .clr_i      (ext_clr[p]),
      .pend_o     (ext_pend[p])
    );
  end

  assign pend = {ext_pend, int_irq_i};

  pic_fiq_path i_fiq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fiq_ni(fiq_ni),
    .clr_i (we_i && addr_i == A_FIQ_CLR),
    .fiq_o (fiq_o)
  );

  pic_arbiter #(.N(N_S), .PRIO_W(P_W), .ID_W(I_W)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .prio_i (prio_flat),
    .valid_o(win_valid),
    .id_o   (win_id),
    .lvl_o  (win_lvl)
  );

  assign irq_o = win_valid;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_S; k++)
      if (addr_i == A_W'(k)) rdata_o[P_W-1:0] = prio_q[k];
    case (addr_i)
      A_CFG:   rdata_o[CFG_W-1:0] = cfg_q;
      A_PEND:  rdata_o[N_S-1:0]   = pend;
      A_WIN:   rdata_o[I_W+P_W:0] = {win_valid, win_lvl, win_id};
      default: ;
    endcase
  end

  p_irq_needs_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (prio_flat[win_id*P_W +: P_W] != '0 && pend[win_id]));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [22:0] int_irq_i = '0;
  logic [3:0]  ext_irq_i = 4'hF;
  logic        fiq_ni = 1'b1;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int checks = 0, fails = 0;
  int prio_m [27];
  bit done = 0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_win(input logic [26:0] pd);
    int bl = 0, bi = 0;
    for (int k = 0; k < 27; k++)
      if (pd[k] && prio_m[k] > bl) begin bl = prio_m[k]; bi = k; end
    return (bl != 0) ? ((32'd1 << 8) | (32'(bl) << 5) | 32'(bi)) : 32'd0;
  endfunction

  task automatic set_prio(input int k, input int v);
    prio_m[k] = v; wr(6'(k), 32'(v));
  endtask

  task automatic chk_win(input logic [26:0] pd, input string req);
    logic [31:0] d, e;
    e = exp_win(pd);
    rd(6'h24, d);
    chk(d == e, req, d, e);
    chk(irq_o == e[8], "R3", 32'(irq_o), 32'(e[8]));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [26:0] pm;
    for (int k = 0; k < 27; k++) prio_m[k] = 0;
    waitn(2); rst_ni = 1'b1; waitn(4);

    // R1 reset state
    chk(irq_o == 1'b0, "R1", 32'(irq_o), 0);
    chk(fiq_o == 1'b0, "R1", 32'(fiq_o), 0);
    rd(6'h05, d); chk(d == 0, "R1", d, 0);
    rd(6'h20, d); chk(d == 0, "R1", d, 0);
    rd(6'h24, d); chk(d == 0, "R1", d, 0);

    // R5 raw pending, R2 disabled sources
    int_irq_i = '1; waitn(1);
    rd(6'h23, d); chk(d == 32'h007F_FFFF, "R5", d, 32'h007F_FFFF);
    chk(irq_o == 1'b0, "R2", 32'(irq_o), 0);

    // R11 priority programming, scattered pattern
    for (int k = 0; k < 27; k++) set_prio(k, (k * 5 + 3) % 8);
    for (int k = 0; k < 27; k++) begin
      rd(6'(k), d); chk(d == 32'(prio_m[k]), "R11", d, 32'(prio_m[k]));
    end

    // R4 sweep: remove the winner each step
    pm = {4'h0, 23'h7F_FFFF};
    for (int s = 0; s < 24; s++) begin
      chk_win(pm, "R4");
      d = exp_win(pm);
      if (d[8]) begin pm[d[4:0]] = 1'b0; int_irq_i[d[4:0]] = 1'b0; waitn(1); end
    end
    // R2 remaining pending sources all have level 0
    chk(irq_o == 1'b0, "R2", 32'(irq_o), 0);
    rd(6'h23, d); chk(d[22:0] == pm[22:0], "R5", d, 32'(pm));

    // R4 ties go to lowest index
    for (int k = 0; k < 27; k++) set_prio(k, (k < 23) ? 2 : 0);
    int_irq_i = 23'h40_0A50; waitn(1);
    chk_win(27'h40_0A50, "R4");
    int_irq_i = 23'h40_0A00; waitn(1);
    chk_win(27'h40_0A00, "R4");
    int_irq_i = '0;
    for (int k = 0; k < 23; k++) set_prio(k, 0);
    for (int k = 23; k < 27; k++) set_prio(k, 7);

    // R6 level low (reset config), pins idle high
    waitn(2); chk(irq_o == 1'b0, "R6", 32'(irq_o), 0);
    ext_irq_i[0] = 1'b0; waitn(4);
    chk_win(27'(1) << 23, "R6");
    ext_irq_i[0] = 1'b1; waitn(4);
    chk(irq_o == 1'b0, "R6", 32'(irq_o), 0);
    // R6 level high
    wr(6'h20, 32'h01);
    chk_win(27'(1) << 23, "R6");
    ext_irq_i[0] = 1'b0; waitn(4);
    rd(6'h23, d); chk(d[23] == 1'b0, "R6", d, 0);
    chk(irq_o == 1'b0, "R6", 32'(irq_o), 0);

    // R10 two-edge latency
    ext_irq_i[0] = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk(irq_o == 1'b0, "R10", 32'(irq_o), 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(irq_o == 1'b1, "R10", 32'(irq_o), 1);
    ext_irq_i[0] = 1'b0; waitn(4);

    // R7 rising edge on pin 2
    wr(6'h20, 32'h31);
    ext_irq_i[2] = 1'b0; waitn(4);
    rd(6'h23, d); chk(d[25] == 1'b0, "R7", d, 0);
    ext_irq_i[2] = 1'b1; waitn(4);
    chk_win(27'(1) << 25, "R7");
    ext_irq_i[2] = 1'b0; waitn(4);
    rd(6'h23, d); chk(d[25] == 1'b1, "R7", d, 32'(1) << 25);
    // R8 clear aimed elsewhere, then at the source
    wr(6'h21, 32'd24);
    rd(6'h23, d); chk(d[25] == 1'b1, "R8", d, 32'(1) << 25);
    wr(6'h21, 32'd25);
    rd(6'h23, d); chk(d[25] == 1'b0, "R8", d, 0);
    chk(irq_o == 1'b0, "R8", 32'(irq_o), 0);

    // R7 falling edge on pin 3
    wr(6'h20, 32'hB1);
    ext_irq_i[3] = 1'b0; waitn(4);
    chk_win(27'(1) << 26, "R7");
    ext_irq_i[3] = 1'b1; waitn(4);
    rd(6'h23, d); chk(d[26] == 1'b1, "R7", d, 32'(1) << 26);
    wr(6'h21, 32'd26);
    rd(6'h23, d); chk(d[26] == 1'b0, "R8", d, 0);

    // R8 clear has no effect on a level source
    int_irq_i[3] = 1'b1; waitn(1);
    wr(6'h21, 32'd3);
    rd(6'h23, d); chk(d[3] == 1'b1, "R8", d, 32'h8);
    int_irq_i[3] = 1'b0;

    // R9 fast interrupt path
    fiq_ni = 1'b0; waitn(4);
    chk(fiq_o == 1'b1, "R9", 32'(fiq_o), 1);
    fiq_ni = 1'b1; waitn(4);
    chk(fiq_o == 1'b1, "R9", 32'(fiq_o), 1);
    wr(6'h22, 32'd0);
    chk(fiq_o == 1'b0, "R9", 32'(fiq_o), 0);
    waitn(4);
    chk(fiq_o == 1'b0, "R9", 32'(fiq_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule